// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator

This block is the frequency-control accumulator of a direct digital synthesizer. On every clock it adds a static increment word to a running phase value modulo 2^W. No carry travels across the full width in one clock. The width is cut into W/2 slices of two bits each. Every slice holds its own 2-bit sum register and hands a registered carry to the slice above it. Slice k therefore works on accumulation step j one cycle after slice k-1 did. A triangle of 2-bit alignment registers then delays the lower slices, with slice k getting n-1-k stages for n = W/2. All bits of one step reach the output in the same cycle, so the output can drive a converter directly.

An activity token travels up the slice chain after reset. A slice starts adding only once the token reaches it, so every slice begins at step zero with a clean carry. The increment is treated as quasi-static and is not skewed per slice. A small control state machine watches for a change of the increment and marks the output valid only when every bit belongs to one consistent step.

The control machine has three states. ST_FILL waits for the token to reach the top slice. ST_LIVE means the output is aligned and correct. ST_SETTLE counts out a changed increment. Transitions:
- fill_done (ST_FILL to ST_LIVE) when the top slice has become active.
- inc_moved (any state to ST_SETTLE, restarting the count) when the increment differs from its value at the previous edge.
- settle_done (ST_SETTLE to ST_LIVE) after n-1 edges counted from the change.

Synchronous reset returns the machine to ST_FILL and clears all sum, carry, token and alignment registers. The copy of the increment used for change detection follows the input on every edge.

Top module: `phase_acc_pipe`

## Requirements
- R1: While reset is high, and after any clock edge that samples reset high, acc_o is 0 and valid_o is 0.
- R2: With a constant increment, valid_o goes high after exactly the n-th clock edge following reset release (n = W/2), and stays high while the increment is constant.
- R3: After the m-th edge following reset release, for m >= n, acc_o equals (m-n+1)*inc_i mod 2^W. The first valid value is therefore the increment itself.
- R4: Two consecutive valid outputs differ by the increment modulo 2^W. The value wraps through zero with no flag or stall.
- R5: If inc_i at an edge e differs from its value at the previous edge, valid_o is low after edges e through e+n-2. It is high again after edge e+n-1 if no further change occurs.
- R6: From edge e+n-1 on, consecutive outputs differ by the new increment modulo 2^W.
- R7: An increment of 0 keeps acc_o at 0. An all-ones increment lowers acc_o by one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_i | input | W | Quasi-static frequency increment word |
| acc_o | output | W | Aligned accumulator value |
| valid_o | output | 1 | High when acc_o holds one consistent accumulation step |

## Verification
After reset release, the top slice's bits need no alignment. So the first valid value is due after the n-th edge, and the step count seen at acc_o trails the edge count by n-1. The bench counts edges from reset release and samples one time unit after each edge. It compares against (m-n+1)*inc computed arithmetically for two widths at once, and sweeps all 256 increments for W=8 and all 16 for W=4. For an increment change, the edge that first sees the new value is counted as zero. valid_o is expected low through edge n-2 and high from edge n-1, where the step by the new increment is checked.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;

    localparam int SLICE_BITS = 2;

    typedef logic [SLICE_BITS-1:0] dibit_t;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_LIVE   = 2'd1,
        ST_SETTLE = 2'd2
    } fill_state_e;

endpackage

// File: rtl/pacc_slice.sv
module pacc_slice
    import phase_acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   act_i,
    input  dibit_t inc_i,
    input  logic   cin_i,
    output dibit_t sum_o,
    output logic   cout_o,
    output logic   act_o
);

    dibit_t     sum_q;
    logic       cy_q;
    logic       act_q;
    logic [2:0] total;

    // full 2-bit add of increment, held sum and incoming carry
    always_comb begin
        total = {1'b0, sum_q} + {1'b0, inc_i} + {2'b00, cin_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cy_q  <= 1'b0;
            act_q <= 1'b0;
        end else begin
            act_q <= act_i;
            if (act_i) begin
                sum_q <= total[1:0];
                cy_q  <= total[2];
            end else begin
                cy_q  <= 1'b0;
            end
        end
    end

    assign sum_o  = sum_q;
    assign cout_o = cy_q;
    assign act_o  = act_q;

    // a slice not yet reached by the token keeps its cleared state (R1)
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !act_i |=> (sum_q == 2'b00 && !cy_q));

    // once active, a slice stays active until reset (R2)
    assert_act_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        act_q |=> act_q);

endmodule

// File: rtl/pacc_align.sv
module pacc_align
    import phase_acc_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  dibit_t d_i,
    output dibit_t q_o
);

    dibit_t stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage[i] <= '0;
            end
        end else begin
            stage[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q_o = stage[DEPTH-1];

endmodule

// File: rtl/pacc_ctrl.sv
module pacc_ctrl
    import phase_acc_pkg::*;
#(
    parameter int W = 8,
    parameter int N = W / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_i,
    input  logic         primed_i,
    output logic         valid_o
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] SETTLE_LAST = (N >= 2) ? CW'(N - 2) : '0;

    fill_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  inc_q;
    logic          inc_moved;

    // reference copy tracks the input every edge, reset included
    always_ff @(posedge clk) begin
        inc_q <= inc_i;
    end

    assign inc_moved = (inc_i != inc_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (inc_moved) begin
                cnt_q <= '0;
            end else if (state_q == ST_SETTLE) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (inc_moved)     state_d = ST_SETTLE;
                else if (primed_i) state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (inc_moved)     state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (inc_moved)                 state_d = ST_SETTLE;
                else if (cnt_q == SETTLE_LAST) state_d = ST_LIVE;
            end
            default: state_d = ST_FILL;
        endcase
    end

    // outputs
    always_comb begin
        valid_o = (state_q == ST_LIVE);
    end

    assert_move_drops_R5: assert property (@(posedge clk) disable iff (rst)
        inc_moved |=> !valid_o);

    assert_live_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LIVE && !inc_moved) |=> valid_o);

    assert_settle_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SETTLE) |-> (cnt_q <= SETTLE_LAST));

endmodule

// File: rtl/phase_acc_pipe.sv
module phase_acc_pipe
    import phase_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] inc_i,
    output logic [W-1:0] acc_o,
    output logic         valid_o
);

    localparam int N = W / SLICE_BITS;

    logic [N-1:0] act_in;
    logic [N-1:0] act_out;
    logic [N-1:0] cy_in;
    logic [N-1:0] cy_out;
    dibit_t       raw     [N];
    dibit_t       aligned [N];
    logic         tail_act;
    logic         spill_cy;

    for (genvar k = 0; k < N; k++) begin : g_slice
        if (k == 0) begin : g_base
            assign act_in[k] = 1'b1;
            assign cy_in[k]  = 1'b0;
        end else begin : g_link
            assign act_in[k] = act_out[k-1];
            assign cy_in[k]  = cy_out[k-1];
        end

        pacc_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .act_i  (act_in[k]),
            .inc_i  (inc_i[SLICE_BITS*k +: SLICE_BITS]),
            .cin_i  (cy_in[k]),
            .sum_o  (raw[k]),
            .cout_o (cy_out[k]),
            .act_o  (act_out[k])
        );

        if (k < N - 1) begin : g_delay
            pacc_align #(.DEPTH(N - 1 - k)) u_align (
                .clk (clk),
                .rst (rst),
                .d_i (raw[k]),
                .q_o (aligned[k])
            );
        end else begin : g_direct
            assign aligned[k] = raw[k];
        end

        assign acc_o[SLICE_BITS*k +: SLICE_BITS] = aligned[k];
    end

    assign tail_act = act_out[N-1];
    assign spill_cy = cy_out[N-1];

    pacc_ctrl #(.W(W), .N(N)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .inc_i    (inc_i),
        .primed_i (act_in[N-1]),
        .valid_o  (valid_o)
    );

    assert_primed_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> tail_act);

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o)) |-> (acc_o == W'($past(acc_o) + $past(inc_i))));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o)) |-> (spill_cy == (acc_o < $past(acc_o))));

endmodule

// File: tb/phase_acc_pipe_bench.sv
module phase_acc_pipe_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] inc8 = '0;
    logic [3:0] inc4 = '0;
    logic [7:0] acc8;
    logic [3:0] acc4;
    logic       v8;
    logic       v4;
    int         checks = 0;
    int         fails  = 0;

    always #2 clk = ~clk;

    phase_acc_pipe #(.W(8)) u_phase_acc_pipe (
        .clk (clk), .rst (rst), .inc_i (inc8), .acc_o (acc8), .valid_o (v8)
    );

    phase_acc_pipe #(.W(4)) u_phase_acc_pipe_w4 (
        .clk (clk), .rst (rst), .inc_i (inc4), .acc_o (acc4), .valid_o (v4)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(acc8 == 8'd0, "R1", int'(acc8), 0);
        chk(v8 == 1'b0,   "R1", int'(v8),   0);
        chk(acc4 == 4'd0, "R1", int'(acc4), 0);
        chk(v4 == 1'b0,   "R1", int'(v4),   0);
        rst = 1'b0;
    endtask

    // constant increment from reset; n = 4 for W=8, n = 2 for W=4
    task automatic sweep(input logic [7:0] i8, input logic [3:0] i4, input int cycles);
        string t8;
        string t4;
        logic [7:0] p8;
        logic [3:0] p4;
        t8 = (i8 == 8'd0 || i8 == 8'hFF) ? "R7" : "R3";
        t4 = (i4 == 4'd0 || i4 == 4'hF)  ? "R7" : "R3";
        inc8 = i8;
        inc4 = i4;
        do_reset();
        p8 = '0;
        p4 = '0;
        for (int m = 1; m <= cycles; m++) begin
            @(posedge clk);
            #1;
            chk(v8 == (m >= 4), "R2", int'(v8), int'(m >= 4));
            chk(v4 == (m >= 2), "R2", int'(v4), int'(m >= 2));
            if (m >= 4) chk(acc8 == 8'((m - 3) * int'(i8)), t8, int'(acc8), int'(8'((m - 3) * int'(i8))));
            if (m >= 2) chk(acc4 == 4'((m - 1) * int'(i4)), t4, int'(acc4), int'(4'((m - 1) * int'(i4))));
            if (m > 4) chk(acc8 == 8'(p8 + i8), "R4", int'(acc8), int'(8'(p8 + i8)));
            if (m > 2) chk(acc4 == 4'(p4 + i4), "R4", int'(acc4), int'(4'(p4 + i4)));
            p8 = acc8;
            p4 = acc4;
        end
    endtask

    // increment change after the pipeline is live
    task automatic change(input logic [7:0] a8, input logic [7:0] b8,
                          input logic [3:0] a4, input logic [3:0] b4);
        logic [7:0] p8;
        logic [3:0] p4;
        inc8 = a8;
        inc4 = a4;
        do_reset();
        repeat (10) @(posedge clk);
        #1;
        p8 = acc8;
        p4 = acc4;
        inc8 = b8;
        inc4 = b4;
        for (int k = 0; k <= 12; k++) begin
            @(posedge clk);
            #1;
            chk(v8 == (k >= 3), "R5", int'(v8), int'(k >= 3));
            chk(v4 == (k >= 1), "R5", int'(v4), int'(k >= 1));
            if (k >= 3) chk(acc8 == 8'(p8 + b8), "R6", int'(acc8), int'(8'(p8 + b8)));
            if (k >= 1) chk(acc4 == 4'(p4 + b4), "R6", int'(acc4), int'(4'(p4 + b4)));
            p8 = acc8;
            p4 = acc4;
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) begin
            sweep(8'(i), 4'(i), 24);
        end
        change(8'd3,   8'd200, 4'd3,  4'd12);
        change(8'hFF,  8'd1,   4'hF,  4'd1);
        change(8'd0,   8'd7,   4'd0,  4'd7);
        change(8'd7,   8'd0,   4'd7,  4'd0);
        change(8'd85,  8'd170, 4'd5,  4'd10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule